// File: doc/BRIEF.md
# Vertical 3-to-5 interpolating line scaler

This block stretches a TV-timed picture vertically so that it fills a taller flat panel. Visible source lines arrive in groups of three; for each group the block emits five panel lines. With the default 288 visible source lines (a 16-line top border, 256 picture lines and a 16-line bottom border out of a 312-line source frame) the five-for-three expansion yields 480 panel lines. Each panel pixel is a blend of the same horizontal position in the buffered source lines. The blend is the sum of four taps, and the weights are set by repeating a line among the taps.

Pixels enter as 8-bit words with blue in bits 7:6, green in bits 5:3 and red in bits 2:0. The block holds the three lines of a group in one bank of line memories while the source fills the other bank. Once a group is complete, it reads the group back through a three-stage adder. It also generates the panel's line sync, frame sync and data enable.

One phase of each group may be left out of the panel raster to save line time. The panel still expects a fixed number of line syncs per frame, so padding syncs are issued after the last group and the total per frame stays constant. Source lines beyond the visible count in a frame are discarded.

Top module: `vscale35`

## Requirements
- R1: While and right after synchronous reset, out_hs, out_vs and out_de are low.
- R2: For every three accepted source lines s0, s1, s2, output lines are produced in phase order 0..4. The phases use the taps (s0,s0,s0,s0), (s0,s0,s0,s1), (s1,s1,s1,s1), (s1,s1,s2,s2) and (s2,s2,s2,s2), each taken at the same pixel position.
- R3: Each channel of an output pixel equals the sum of the four tap channels plus 1, formed in 5 bits. Input layout is blue [7:6], green [5:3], red [2:0]. Output layout is blue [14:10], green [9:5], red [4:0].
- R4: The phase numbered DROP_PHASE (when below 5) is never output: it gets no line sync and no data, and each group then yields four lines.
- R5: Each frame carries exactly HS_TOTAL line sync pulses, counted from one out_vs to the next. Padding pulses, one per HBLANK+LINE_W cycles, follow the last group.
- R6: Every output line is a single line sync pulse followed by exactly LINE_W contiguous data-enable cycles. out_hs, out_vs and out_de are never high together.
- R7: A src_sof pulse produces one out_vs pulse and restarts the frame, so the next group starts again at its first phase with a full sync count.
- R8: Source lines after the first VIS_LINES of a frame are ignored and produce no panel line, sync or data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sof | input | 1 | One-cycle pulse at the start of a source frame |
| src_valid | input | 1 | Source pixel strobe |
| src_px | input | 8 | Source pixel, BGR233 |
| src_eol | input | 1 | Marks the last pixel of a source line, with src_valid |
| out_hs | output | 1 | Panel line sync pulse |
| out_vs | output | 1 | Panel frame sync pulse |
| out_de | output | 1 | Panel data enable |
| out_px | output | 15 | Panel pixel, BGR555 |

## Verification
A wrong phase counter or tap selection shows up in the first pixel of the affected line as a blend that does not match the tap table. A ping-pong bank mixed up between write and read shows up as pixels from the wrong group as soon as the second group of a frame is read out. A sync counter that drifts shows up at frame end as too many or too few padding pulses between two frame syncs. A dropped phase that is not suppressed adds a fifth data line in the very first group.

// File: rtl/vs_scale_pkg.sv
package vs_scale_pkg;

    typedef struct packed {
        logic [1:0] b;
        logic [2:0] g;
        logic [2:0] r;
    } px233_t;

    typedef struct packed {
        logic [4:0] b;
        logic [4:0] g;
        logic [4:0] r;
    } px555_t;

    localparam int NPHASE = 5;
    localparam int NSLOT  = 3;

    // Which buffered line feeds tap k of output phase ph.
    function automatic logic [1:0] tap_line(input logic [2:0] ph, input int k);
        case (ph)
            3'd0:    tap_line = 2'd0;
            3'd1:    tap_line = (k == 3) ? 2'd1 : 2'd0;
            3'd2:    tap_line = 2'd1;
            3'd3:    tap_line = (k < 2) ? 2'd1 : 2'd2;
            default: tap_line = 2'd2;
        endcase
    endfunction

    function automatic px555_t widen(input px233_t p);
        widen.b = {3'b000, p.b};
        widen.g = {2'b00, p.g};
        widen.r = {2'b00, p.r};
    endfunction

    function automatic px555_t add_px(input px555_t x, input px555_t y, input logic cin);
        add_px.b = x.b + y.b + {4'b0000, cin};
        add_px.g = x.g + y.g + {4'b0000, cin};
        add_px.r = x.r + y.r + {4'b0000, cin};
    endfunction

endpackage

// File: rtl/vs_linebuf.sv
module vs_linebuf
    import vs_scale_pkg::*;
#(
    parameter int LINE_W    = 256,
    parameter int VIS_LINES = 288,
    localparam int XW = (LINE_W > 1) ? $clog2(LINE_W) : 1,
    localparam int LW = $clog2(VIS_LINES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sof,
    input  logic          src_valid,
    input  px233_t        src_px,
    input  logic          src_eol,
    input  logic [XW-1:0] rd_x,
    output px233_t        rd_q [NSLOT],
    output logic          grp_go
);
    logic          wb, rb;
    logic [1:0]    ws;
    logic [XW-1:0] wa;
    logic [LW-1:0] lines;
    logic          accept;
    logic [7:0]    q [2*NSLOT];

    assign accept = src_valid && (lines < LW'(VIS_LINES));

    always_ff @(posedge clk) begin
        if (rst) begin
            wb <= 1'b0; rb <= 1'b0; ws <= 2'd0; wa <= '0; lines <= '0; grp_go <= 1'b0;
        end else if (sof) begin
            ws <= 2'd0; wa <= '0; lines <= '0; grp_go <= 1'b0;
        end else begin
            grp_go <= accept && src_eol && (ws == 2'd2);
            if (accept) begin
                wa <= src_eol ? '0 : wa + 1'b1;
                if (src_eol) begin
                    lines <= lines + 1'b1;
                    if (ws == 2'd2) begin
                        ws <= 2'd0;
                        wb <= ~wb;
                        rb <= wb;
                    end else begin
                        ws <= ws + 1'b1;
                    end
                end
            end
        end
    end

    for (genvar g = 0; g < 2*NSLOT; g++) begin : g_ram
        logic [7:0] ram [LINE_W];
        logic       sel;
        assign sel = accept && ((wb ? 3 : 0) + int'(ws) == g);
        always_ff @(posedge clk) begin
            if (sel) ram[wa] <= src_px;
            q[g] <= ram[rd_x];
        end
    end

    for (genvar s = 0; s < NSLOT; s++) begin : g_rd
        assign rd_q[s] = rb ? px233_t'(q[NSLOT+s]) : px233_t'(q[s]);
    end

    assert_line_limit_R8: assert property (@(posedge clk) disable iff (rst)
        lines <= LW'(VIS_LINES));

endmodule

// File: rtl/vs_mix4.sv
module vs_mix4
    import vs_scale_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  px233_t a,
    input  px233_t b,
    input  px233_t c,
    input  px233_t d,
    output px555_t mix
);
    px555_t s1, s2, s3;
    px233_t c_q, d_q, d_q2;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0; s2 <= '0; s3 <= '0; c_q <= '0; d_q <= '0; d_q2 <= '0;
        end else begin
            s1   <= add_px(widen(a), widen(b), 1'b0);
            c_q  <= c;
            d_q  <= d;
            s2   <= add_px(s1, widen(c_q), 1'b0);
            d_q2 <= d_q;
            s3   <= add_px(s2, widen(d_q2), 1'b1);
        end
    end

    assign mix = s3;

    assert_sum_range_R3: assert property (@(posedge clk) disable iff (rst)
        (s3.b <= 5'd13) && (s3.g <= 5'd29) && (s3.r <= 5'd29));

endmodule

// File: rtl/vs_seq.sv
module vs_seq
    import vs_scale_pkg::*;
#(
    parameter int LINE_W     = 256,
    parameter int HBLANK     = 16,
    parameter int GROUPS     = 96,
    parameter int HS_TOTAL   = 525,
    parameter int DROP_PHASE = 0,
    localparam int LP  = LINE_W + HBLANK,
    localparam int HCW = $clog2(LP),
    localparam int XW  = (LINE_W > 1) ? $clog2(LINE_W) : 1,
    localparam int GW  = $clog2(GROUPS + 1),
    localparam int HSW = $clog2(HS_TOTAL + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sof,
    input  logic          grp_go,
    output logic          hs_raw,
    output logic          de_raw,
    output logic          vs_raw,
    output logic [2:0]    phase,
    output logic [XW-1:0] rd_x
);
    typedef enum logic [1:0] {S_IDLE, S_LINE, S_PAD, S_DONE} st_t;
    localparam logic [2:0] FIRST = (DROP_PHASE == 0) ? 3'd1 : 3'd0;

    st_t            state;
    logic [HCW-1:0] hc, hc_off;
    logic [GW-1:0]  grp;
    logic [HSW-1:0] hs_cnt;
    logic [2:0]     np;

    always_comb begin
        np = phase + 3'd1;
        if (int'(np) == DROP_PHASE) np = np + 3'd1;
    end

    assign hc_off = hc - HCW'(HBLANK);
    assign rd_x   = hc_off[XW-1:0];
    assign de_raw = (state == S_LINE) && (hc >= HCW'(HBLANK));
    assign hs_raw = (hc == '0) &&
                    ((state == S_LINE) || (state == S_PAD && hs_cnt < HSW'(HS_TOTAL)));
    assign vs_raw = sof && !rst;

    always_ff @(posedge clk) begin
        if (rst || sof) begin
            state <= S_IDLE; phase <= FIRST; hc <= '0; grp <= '0; hs_cnt <= '0;
        end else begin
            if (hs_raw) hs_cnt <= hs_cnt + 1'b1;
            case (state)
                S_IDLE: if (grp_go) begin
                    state <= S_LINE; hc <= '0; phase <= FIRST;
                end
                S_LINE: if (hc == HCW'(LP - 1)) begin
                    hc <= '0;
                    if (np >= 3'(NPHASE)) begin
                        grp   <= grp + 1'b1;
                        phase <= FIRST;
                        state <= (grp == GW'(GROUPS - 1)) ? S_PAD : S_IDLE;
                    end else begin
                        phase <= np;
                    end
                end else begin
                    hc <= hc + 1'b1;
                end
                S_PAD: begin
                    hc <= (hc == HCW'(LP - 1)) ? '0 : hc + 1'b1;
                    if (hc == '0 && hs_cnt == HSW'(HS_TOTAL)) state <= S_DONE;
                end
                default: ;
            endcase
        end
    end

    assert_sync_budget_R5: assert property (@(posedge clk) disable iff (rst)
        hs_cnt <= HSW'(HS_TOTAL));

    assert_skip_dropped_R4: assert property (@(posedge clk) disable iff (rst)
        (state == S_LINE) |-> (int'(phase) != DROP_PHASE && phase < 3'(NPHASE)));

endmodule

// File: rtl/vscale35.sv
module vscale35
    import vs_scale_pkg::*;
#(
    parameter int LINE_W     = 256,
    parameter int HBLANK     = 16,
    parameter int VIS_LINES  = 288,
    parameter int HS_TOTAL   = 525,
    parameter int DROP_PHASE = 0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        src_sof,
    input  logic        src_valid,
    input  logic [7:0]  src_px,
    input  logic        src_eol,
    output logic        out_hs,
    output logic        out_vs,
    output logic        out_de,
    output logic [14:0] out_px
);
    localparam int GROUPS = VIS_LINES / NSLOT;
    localparam int XW     = (LINE_W > 1) ? $clog2(LINE_W) : 1;
    localparam int DLY    = 4;

    px233_t        rd_q [NSLOT];
    px233_t        tap  [4];
    px555_t        mix;
    logic          grp_go, hs_raw, de_raw, vs_raw;
    logic [2:0]    phase, phase_d1;
    logic [XW-1:0] rd_x;
    logic [DLY-1:0] hs_sr, de_sr, vs_sr;

    vs_linebuf #(.LINE_W(LINE_W), .VIS_LINES(VIS_LINES)) u_buf (
        .clk(clk), .rst(rst), .sof(src_sof), .src_valid(src_valid),
        .src_px(px233_t'(src_px)), .src_eol(src_eol), .rd_x(rd_x),
        .rd_q(rd_q), .grp_go(grp_go));

    vs_seq #(.LINE_W(LINE_W), .HBLANK(HBLANK), .GROUPS(GROUPS),
             .HS_TOTAL(HS_TOTAL), .DROP_PHASE(DROP_PHASE)) u_seq (
        .clk(clk), .rst(rst), .sof(src_sof), .grp_go(grp_go),
        .hs_raw(hs_raw), .de_raw(de_raw), .vs_raw(vs_raw),
        .phase(phase), .rd_x(rd_x));

    for (genvar k = 0; k < 4; k++) begin : g_tap
        assign tap[k] = rd_q[tap_line(phase_d1, k)];
    end

    vs_mix4 u_mix (.clk(clk), .rst(rst), .a(tap[0]), .b(tap[1]),
                   .c(tap[2]), .d(tap[3]), .mix(mix));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_d1 <= '0; hs_sr <= '0; de_sr <= '0; vs_sr <= '0;
        end else begin
            phase_d1 <= phase;
            hs_sr <= {hs_sr[DLY-2:0], hs_raw};
            de_sr <= {de_sr[DLY-2:0], de_raw};
            vs_sr <= {vs_sr[DLY-2:0], vs_raw};
        end
    end

    assign out_hs = hs_sr[DLY-1];
    assign out_de = de_sr[DLY-1];
    assign out_vs = vs_sr[DLY-1];
    assign out_px = mix;

    assert_sync_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({out_hs, out_de, out_vs}));

endmodule

// File: tb/vscale35_test.sv
module vscale35_test;
    localparam int CLK_PERIOD = 10;
    localparam int LW   = 8;
    localparam int HB   = 4;
    localparam int VIS  = 6;
    localparam int HST  = 12;
    localparam int DROP = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic src_sof = 1'b0, src_valid = 1'b0, src_eol = 1'b0;
    logic [7:0] src_px = '0;
    logic out_hs, out_vs, out_de;
    logic [14:0] out_px;

    int total = 0, bad = 0;
    bit finished = 0;
    logic [14:0] expq [$];
    logic [7:0] lbuf [3][LW];
    int hs_seen = 0, de_lines = 0, vs_seen = 0, run = 0;
    logic de_prev = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vscale35 #(.LINE_W(LW), .HBLANK(HB), .VIS_LINES(VIS), .HS_TOTAL(HST),
               .DROP_PHASE(DROP)) uut (
        .clk(clk), .rst(rst), .src_sof(src_sof), .src_valid(src_valid),
        .src_px(src_px), .src_eol(src_eol), .out_hs(out_hs), .out_vs(out_vs),
        .out_de(out_de), .out_px(out_px));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pix(input int f, input int l, input int x);
        case (f)
            0:       pix = 8'(l * 16 + x * 3);
            1:       pix = (l % 2 == 1) ? 8'hFF : 8'(x);
            default: pix = 8'((l * 37 + x * 11) ^ 8'h5A);
        endcase
    endfunction

    function automatic int tsel(input int p, input int k);
        int t [5][4] = '{'{0,0,0,0}, '{0,0,0,1}, '{1,1,1,1}, '{1,1,2,2}, '{2,2,2,2}};
        tsel = t[p][k];
    endfunction

    task automatic push_group();
        for (int p = 0; p < 5; p++) begin
            if (p == DROP) continue;
            for (int x = 0; x < LW; x++) begin
                int sb = 1, sg = 1, sr = 1;
                for (int k = 0; k < 4; k++) begin
                    logic [7:0] v;
                    v = lbuf[tsel(p, k)][x];
                    sb += v[7:6]; sg += v[5:3]; sr += v[2:0];
                end
                expq.push_back({5'(sb), 5'(sg), 5'(sr)});
            end
        end
    endtask

    task automatic send_line(input int f, input int l, input bit expect_it);
        for (int x = 0; x < LW; x++) begin
            @(negedge clk);
            src_valid = 1'b1;
            src_px = pix(f, l, x);
            src_eol = (x == LW - 1);
            if (expect_it) lbuf[l % 3][x] = src_px;
        end
        @(negedge clk);
        src_valid = 1'b0; src_eol = 1'b0;
        if (expect_it && (l % 3 == 2)) push_group();
        repeat (15) @(negedge clk);
    endtask

    task automatic send_frame(input int f);
        @(negedge clk); src_sof = 1'b1;
        @(negedge clk); src_sof = 1'b0;
        for (int l = 0; l < VIS; l++) send_line(f, l, 1'b1);
        repeat (200) @(negedge clk);
        // R2 R3: every expected pixel consumed
        check(expq.size() == 0, "R2 queue drained", expq.size(), 0);
        // R5: sync count per frame including padding
        check(hs_seen == HST, "R5 hsync total", hs_seen, HST);
        // R4: dropped phase leaves four lines per group
        check(de_lines == (VIS / 3) * 4, "R4 data lines", de_lines, (VIS / 3) * 4);
        // R7: one frame sync per frame
        check(vs_seen == f + 1, "R7 vsync count", vs_seen, f + 1);
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (out_vs) begin hs_seen = 0; de_lines = 0; vs_seen++; end
            if (out_hs) hs_seen++;
            if (out_de) begin
                if (!de_prev) begin de_lines++; run = 0; end
                run++;
                if (expq.size() == 0) check(1'b0, "R2 unexpected pixel", int'(out_px), -1);
                else begin
                    logic [14:0] e;
                    e = expq.pop_front();
                    check(out_px == e, "R3 pixel", int'(out_px), int'(e));
                end
            end else if (de_prev) begin
                check(run == LW, "R6 line length", run, LW);
            end
            de_prev = out_de;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            check(1'b0, "watchdog", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check({out_hs, out_vs, out_de} == 3'b000, "R1 reset outputs", int'({out_hs, out_vs, out_de}), 0);
        rst = 1'b0;
        @(negedge clk);
        check({out_hs, out_vs, out_de} == 3'b000, "R1 after reset", int'({out_hs, out_vs, out_de}), 0);
        for (int f = 0; f < 3; f++) begin
            send_frame(f);
            if (f == 1) begin
                int h0, d0;
                h0 = hs_seen; d0 = de_lines;
                // R8: surplus source lines produce nothing
                send_line(f, 0, 1'b0);
                send_line(f, 1, 1'b0);
                send_line(f, 2, 1'b0);
                repeat (100) @(negedge clk);
                check(hs_seen == h0, "R8 no extra hsync", hs_seen, h0);
                check(de_lines == d0, "R8 no extra data", de_lines, d0);
            end
        end
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule